// File: doc/BRIEF.md
# Scanline Timing and Interrupt Flag Generator

This block keeps the raster position of a tile-based video display processor. It counts master-clock cycles across each scanline and scanlines across each frame. From that position it derives the horizontal-blank and vertical-blank bits of the status word. It also raises a vertical-interrupt-pending flag at one exact cycle of the first line below the active picture.

Two horizontal modes are supported. In the wide mode an access slot is 16 master clocks long. In the narrow mode a slot is 20 master clocks long. In the wide mode the sync interval is a fixed 332 clocks, which is not a whole number of slots, so the interrupt and blank edges in that mode sit at cycle positions offset by that interval. All timing decisions use a copy of the mode bits that is captured once per line, so a change to a mode input in the middle of a line has no effect until the next line.

A combinational next-interrupt output gives the absolute cycle within the frame at which the next interrupt will be raised. Another block can use it to schedule work without polling the flag.

Top module: `scanline_timer`

## Requirements
- R1: The cycle counter `cycle_o` advances by one on every clock and runs from 0 to LINE_CLKS-1 (3420 by default). After the last cycle it returns to 0 and `line_o` advances by one.
- R2: The line counter wraps to 0 after the last line of the frame. A frame has NTSC_LINES lines (262 by default) when the latched PAL bit is 0, and PAL_LINES lines (313 by default) when it is 1.
- R3: `status_o[2]` (horizontal blank) is 1 while `cycle_o` is below the clear point and 0 otherwise. The clear point is 912 when the latched wide bit is 1 and 890 when it is 0.
- R4: `status_o[3]` (vertical blank) is 1 while `line_o` is at or above the active-line count and 0 otherwise. The active-line count is NTSC_ACTIVE (224) when the latched PAL bit is 0 and PAL_ACTIVE (240) when it is 1. `status_o[1:0]` are always 0.
- R5: When `vint_en_i` is 1, `line_o` equals the active-line count and `cycle_o` equals the interrupt cycle, `vint_pending_o` becomes 1 at the clock edge that ends that cycle. The interrupt cycle is 812 in the wide mode and 1200 in the narrow mode.
- R6: `vint_pending_o` stays 1 until a clock edge at which `vint_ack_i` is 1, and is then 0. If an acknowledge and a set fall on the same edge, the acknowledge wins and the flag is 0.
- R7: While `vint_en_i` is 0 the flag is never set, and `next_vint_o` is 0xFFFFFFFF.
- R8: While `vint_en_i` is 1, `next_vint_o` equals active-line count × LINE_CLKS + interrupt cycle. It reads 0xFFFFFFFF once the current frame position (`line_o` × LINE_CLKS + `cycle_o`) is beyond that value.
- R9: The mode inputs (`wide_mode_i`: 1 = wide, 0 = narrow; `pal_mode_i`: 1 = PAL, 0 = NTSC) are captured during reset and at the edge that ends the last cycle of each line. A change in the middle of a line only takes effect from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_mode_i | input | 1 | Horizontal mode request: 1 = wide, 0 = narrow |
| pal_mode_i | input | 1 | Vertical standard request: 1 = PAL, 0 = NTSC |
| vint_en_i | input | 1 | Vertical interrupt enable |
| vint_ack_i | input | 1 | Clears the pending flag |
| cycle_o | output | CW ($clog2(LINE_CLKS)) | Master-clock position within the line |
| line_o | output | LW ($clog2(PAL_LINES)) | Line position within the frame |
| status_o | output | 4 | Bit 3 vertical blank, bit 2 horizontal blank, bits 1:0 zero |
| vint_pending_o | output | 1 | Vertical interrupt pending |
| next_vint_o | output | 32 | Frame cycle of the next interrupt, or all ones if none is due |

## Verification
Setting the interrupt flag and acknowledging it are the two functions that can fall on the same clock edge. To provoke this, the bench holds `vint_ack_i` high exactly while the counters sit on the interrupt cycle of the first blank line. It then judges that the flag reads 0 just after that edge and stays 0 for the rest of the line. The same run first shows, one frame earlier, that the flag does rise on that cycle when no acknowledge is present. This makes the 0 in the collision case an outcome of priority rather than of a missed set.

// File: rtl/scanline_pkg.sv
// Package: shared types and status-word bit positions for the scanline timer.
// Assumes: status word is 4 bits wide and decoded by a neighbouring block.
package scanline_pkg;

    // Mode bits as held for the duration of one line.
    typedef struct packed {
        logic wide;   // 1 = wide horizontal mode, 0 = narrow
        logic pal;    // 1 = PAL frame, 0 = NTSC frame
    } line_mode_t;

    localparam int STATUS_W   = 4;
    localparam int ST_VBLANK  = 3;
    localparam int ST_HBLANK  = 2;

endpackage

// File: rtl/st_mode_latch.sv
// Module: st_mode_latch
// Holds the mode bits used for all timing decisions of the current line.
// Assumes: line_end_i is high during the last cycle of each line; the live
// inputs are loaded in reset and at the edge that closes each line.
module st_mode_latch
    import scanline_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_end_i,
    input  logic       wide_i,
    input  logic       pal_i,
    output line_mode_t mode_o
);

    // Capture live mode at reset and at each line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o.wide <= wide_i;
            mode_o.pal  <= pal_i;
        end else if (line_end_i) begin
            mode_o.wide <= wide_i;
            mode_o.pal  <= pal_i;
        end
    end

endmodule

// File: rtl/st_counters.sv
// Module: st_counters
// Cycle-within-line and line-within-frame counters.
// Assumes: frame length is selected by the latched PAL bit of the line that
// is ending; a line index beyond the shorter frame also wraps to zero.
module st_counters #(
    parameter int LINE_CLKS  = 3420,
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 313,
    localparam int CW = $clog2(LINE_CLKS),
    localparam int LW = $clog2(PAL_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pal_i,
    output logic [CW-1:0] cycle_o,
    output logic [LW-1:0] line_o,
    output logic          line_end_o
);

    localparam logic [CW-1:0] LAST_CYC  = CW'(LINE_CLKS - 1);
    localparam logic [LW-1:0] NTSC_LAST = LW'(NTSC_LINES - 1);
    localparam logic [LW-1:0] PAL_LAST  = LW'(PAL_LINES - 1);

    logic [LW-1:0] frame_last;

    // Pick the last line index of the frame from the latched standard.
    always_comb begin
        frame_last = pal_i ? PAL_LAST : NTSC_LAST;
        line_end_o = (cycle_o == LAST_CYC);
    end

    // Advance cycle every clock; advance or wrap line at end of line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_o <= '0;
            line_o  <= '0;
        end else if (line_end_o) begin
            cycle_o <= '0;
            line_o  <= (line_o >= frame_last) ? '0 : line_o + 1'b1;
        end else begin
            cycle_o <= cycle_o + 1'b1;
        end
    end

endmodule

// File: rtl/st_flags.sv
// Module: st_flags
// Status-word blank bits and the vertical-interrupt-pending register.
// Assumes: cycle/line come from st_counters and mode from st_mode_latch;
// acknowledge has priority over a set on the same edge.
module st_flags
    import scanline_pkg::*;
#(
    parameter int CW            = 12,
    parameter int LW            = 9,
    parameter int NTSC_ACTIVE   = 224,
    parameter int PAL_ACTIVE    = 240,
    parameter int WIDE_VINT     = 812,
    parameter int NARROW_VINT   = 1200,
    parameter int WIDE_HB_CLR   = 912,
    parameter int NARROW_HB_CLR = 890
) (
    input  logic                clk,
    input  logic                rst_n,
    input  line_mode_t          mode_i,
    input  logic [CW-1:0]       cycle_i,
    input  logic [LW-1:0]       line_i,
    input  logic                vint_en_i,
    input  logic                vint_ack_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                vint_pending_o
);

    logic [CW-1:0] vint_cyc;
    logic [CW-1:0] hb_clear;
    logic [LW-1:0] active_lines;
    logic          vint_hit;

    // Select mode-dependent edge positions.
    always_comb begin
        vint_cyc     = mode_i.wide ? CW'(WIDE_VINT)   : CW'(NARROW_VINT);
        hb_clear     = mode_i.wide ? CW'(WIDE_HB_CLR) : CW'(NARROW_HB_CLR);
        active_lines = mode_i.pal  ? LW'(PAL_ACTIVE)  : LW'(NTSC_ACTIVE);
        vint_hit     = vint_en_i && (line_i == active_lines) && (cycle_i == vint_cyc);
    end

    // Assemble the status word from the raster position.
    always_comb begin
        status_o            = '0;
        status_o[ST_VBLANK] = (line_i >= active_lines);
        status_o[ST_HBLANK] = (cycle_i < hb_clear);
    end

    // Pending flag: acknowledge clears first, otherwise the hit sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vint_pending_o <= 1'b0;
        end else if (vint_ack_i) begin
            vint_pending_o <= 1'b0;
        end else if (vint_hit) begin
            vint_pending_o <= 1'b1;
        end
    end

endmodule

// File: rtl/st_vint_predict.sv
// Module: st_vint_predict
// Frame cycle at which the next vertical interrupt is due.
// Assumes: all ones means "none due this frame" (disabled or already passed).
module st_vint_predict
    import scanline_pkg::*;
#(
    parameter int LINE_CLKS   = 3420,
    parameter int CW          = 12,
    parameter int LW          = 9,
    parameter int NTSC_ACTIVE = 224,
    parameter int PAL_ACTIVE  = 240,
    parameter int WIDE_VINT   = 812,
    parameter int NARROW_VINT = 1200
) (
    input  line_mode_t    mode_i,
    input  logic [CW-1:0] cycle_i,
    input  logic [LW-1:0] line_i,
    input  logic          vint_en_i,
    output logic [31:0]   next_vint_o
);

    localparam logic [31:0] NTSC_BASE = 32'(NTSC_ACTIVE) * 32'(LINE_CLKS);
    localparam logic [31:0] PAL_BASE  = 32'(PAL_ACTIVE)  * 32'(LINE_CLKS);

    logic [31:0] target;
    logic [31:0] position;

    // Compare the due cycle with the current frame position.
    always_comb begin
        target   = (mode_i.pal ? PAL_BASE : NTSC_BASE)
                 + (mode_i.wide ? 32'(WIDE_VINT) : 32'(NARROW_VINT));
        position = 32'(line_i) * 32'(LINE_CLKS) + 32'(cycle_i);
        if (!vint_en_i || (target < position)) begin
            next_vint_o = '1;
        end else begin
            next_vint_o = target;
        end
    end

endmodule

// File: rtl/scanline_timer.sv
// Module: scanline_timer (top)
// Raster position, blank status bits and vertical-interrupt flag for a tile
// display processor with wide/narrow horizontal modes.
// Assumes: one clock per master-clock cycle; the wide mode's sync interval is
// a fixed clock count that is not a whole number of slots.
module scanline_timer
    import scanline_pkg::*;
#(
    parameter int LINE_CLKS        = 3420,
    parameter int NTSC_ACTIVE      = 224,
    parameter int PAL_ACTIVE       = 240,
    parameter int NTSC_LINES       = 262,
    parameter int PAL_LINES        = 313,
    parameter int WIDE_SLOT_CLKS   = 16,
    parameter int NARROW_SLOT_CLKS = 20,
    parameter int WIDE_SYNC_SLOT   = 21,
    parameter int WIDE_SYNC_CLKS   = 332,
    parameter int WIDE_POST_SLOTS  = 9,
    parameter int NARROW_VINT_SLOTS = 60,
    parameter int NARROW_SYNC_SLOTS = 33,
    parameter int WIDE_HB_TAIL     = 61 * 4,
    parameter int NARROW_HB_TAIL   = 46 * 5,
    localparam int CW = $clog2(LINE_CLKS),
    localparam int LW = $clog2(PAL_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_mode_i,
    input  logic                pal_mode_i,
    input  logic                vint_en_i,
    input  logic                vint_ack_i,
    output logic [CW-1:0]       cycle_o,
    output logic [LW-1:0]       line_o,
    output logic [STATUS_W-1:0] status_o,
    output logic                vint_pending_o,
    output logic [31:0]         next_vint_o
);

    // End of the irregular wide-mode sync region.
    localparam int WIDE_SYNC_END  = WIDE_SYNC_SLOT * WIDE_SLOT_CLKS + WIDE_SYNC_CLKS;
    localparam int WIDE_VINT_CYC  = WIDE_SYNC_END + WIDE_POST_SLOTS * WIDE_SLOT_CLKS;
    localparam int NARROW_VINT_CYC = NARROW_VINT_SLOTS * NARROW_SLOT_CLKS;
    localparam int NARROW_SYNC_END = NARROW_SYNC_SLOTS * NARROW_SLOT_CLKS;
    localparam int WIDE_HB_CLR    = WIDE_SYNC_END + WIDE_HB_TAIL;
    localparam int NARROW_HB_CLR  = NARROW_SYNC_END + NARROW_HB_TAIL;

    line_mode_t mode_q;
    logic       line_end;
    logic       lat_wide;
    logic       lat_pal;

    // Expose latched mode bits for the bound checker.
    always_comb begin
        lat_wide = mode_q.wide;
        lat_pal  = mode_q.pal;
    end

    st_mode_latch i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end_i (line_end),
        .wide_i     (wide_mode_i),
        .pal_i      (pal_mode_i),
        .mode_o     (mode_q)
    );

    st_counters #(
        .LINE_CLKS  (LINE_CLKS),
        .NTSC_LINES (NTSC_LINES),
        .PAL_LINES  (PAL_LINES)
    ) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pal_i      (mode_q.pal),
        .cycle_o    (cycle_o),
        .line_o     (line_o),
        .line_end_o (line_end)
    );

    st_flags #(
        .CW            (CW),
        .LW            (LW),
        .NTSC_ACTIVE   (NTSC_ACTIVE),
        .PAL_ACTIVE    (PAL_ACTIVE),
        .WIDE_VINT     (WIDE_VINT_CYC),
        .NARROW_VINT   (NARROW_VINT_CYC),
        .WIDE_HB_CLR   (WIDE_HB_CLR),
        .NARROW_HB_CLR (NARROW_HB_CLR)
    ) i_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_q),
        .cycle_i        (cycle_o),
        .line_i         (line_o),
        .vint_en_i      (vint_en_i),
        .vint_ack_i     (vint_ack_i),
        .status_o       (status_o),
        .vint_pending_o (vint_pending_o)
    );

    st_vint_predict #(
        .LINE_CLKS   (LINE_CLKS),
        .CW          (CW),
        .LW          (LW),
        .NTSC_ACTIVE (NTSC_ACTIVE),
        .PAL_ACTIVE  (PAL_ACTIVE),
        .WIDE_VINT   (WIDE_VINT_CYC),
        .NARROW_VINT (NARROW_VINT_CYC)
    ) i_pred (
        .mode_i      (mode_q),
        .cycle_i     (cycle_o),
        .line_i      (line_o),
        .vint_en_i   (vint_en_i),
        .next_vint_o (next_vint_o)
    );

endmodule

// File: rtl/scanline_timer_chk.sv
// Module: scanline_timer_chk
// Temporal checks on scanline_timer, attached through bind below.
// Assumes: reset is held low from time zero.
module scanline_timer_chk #(
    parameter int LINE_CLKS   = 3420,
    parameter int PAL_LINES   = 313,
    parameter int NTSC_ACTIVE = 224,
    parameter int PAL_ACTIVE  = 240,
    parameter int WIDE_VINT   = 812,
    parameter int NARROW_VINT = 1200,
    parameter int CW          = 12,
    parameter int LW          = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lat_wide,
    input logic          lat_pal,
    input logic [CW-1:0] cycle_o,
    input logic [LW-1:0] line_o,
    input logic          vblank,
    input logic          hblank,
    input logic          vint_en_i,
    input logic          vint_ack_i,
    input logic          vint_pending_o,
    input logic [31:0]   next_vint_o
);

    localparam logic [CW-1:0] LAST_CYC = CW'(LINE_CLKS - 1);

    // Counter steps by one inside a line (R1).
    p_cycle_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o != LAST_CYC) |=> (cycle_o == $past(cycle_o) + 1'b1));

    // Counter wraps after the last cycle (R1).
    p_cycle_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o == LAST_CYC) |=> (cycle_o == '0));

    // Line index never reaches the longer frame length (R2).
    p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(line_o) < 32'(PAL_LINES)));

    // Horizontal blank only starts at the line start (R3).
    p_hblank_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hblank) |-> (cycle_o == '0));

    // Vertical blank only ends at the first line (R4).
    p_vblank_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> (line_o == '0));

    // Interrupt cycle with enable and no acknowledge sets the flag (R5).
    p_vint_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vint_en_i && !vint_ack_i
         && line_o == (lat_pal ? LW'(PAL_ACTIVE) : LW'(NTSC_ACTIVE))
         && cycle_o == (lat_wide ? CW'(WIDE_VINT) : CW'(NARROW_VINT)))
        |=> vint_pending_o);

    // Acknowledge always leaves the flag clear (R6).
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vint_ack_i |=> !vint_pending_o);

    // Without acknowledge a set flag holds (R6).
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vint_pending_o && !vint_ack_i) |=> vint_pending_o);

    // Disabled interrupt never becomes pending (R7).
    p_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vint_en_i && !vint_pending_o) |=> !vint_pending_o);

    // Disabled interrupt reports no due cycle (R7).
    p_next_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vint_en_i |-> (next_vint_o == 32'hFFFF_FFFF));

endmodule

bind scanline_timer scanline_timer_chk #(
    .LINE_CLKS   (LINE_CLKS),
    .PAL_LINES   (PAL_LINES),
    .NTSC_ACTIVE (NTSC_ACTIVE),
    .PAL_ACTIVE  (PAL_ACTIVE),
    .WIDE_VINT   (WIDE_VINT_CYC),
    .NARROW_VINT (NARROW_VINT_CYC),
    .CW          (CW),
    .LW          (LW)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lat_wide       (lat_wide),
    .lat_pal        (lat_pal),
    .cycle_o        (cycle_o),
    .line_o         (line_o),
    .vblank         (status_o[scanline_pkg::ST_VBLANK]),
    .hblank         (status_o[scanline_pkg::ST_HBLANK]),
    .vint_en_i      (vint_en_i),
    .vint_ack_i     (vint_ack_i),
    .vint_pending_o (vint_pending_o),
    .next_vint_o    (next_vint_o)
);

// File: tb/test_scanline_timer.sv
module test_scanline_timer;

    // Short frames keep the run brief; line length and slot timing stay default.
    localparam int T_LINE       = 3420;
    localparam int T_NTSC_ACT   = 4;
    localparam int T_PAL_ACT    = 6;
    localparam int T_NTSC_LINES = 7;
    localparam int T_PAL_LINES  = 9;
    localparam int CW = $clog2(T_LINE);
    localparam int LW = $clog2(T_PAL_LINES);
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_mode_i = 1'b0;
    logic          pal_mode_i = 1'b0;
    logic          vint_en_i = 1'b0;
    logic          vint_ack_i = 1'b0;
    logic [CW-1:0] cycle_o;
    logic [LW-1:0] line_o;
    logic [3:0]    status_o;
    logic          vint_pending_o;
    logic [31:0]   next_vint_o;

    int checks = 0;
    int failures = 0;
    int ticks = 0;

    always #5 clk = ~clk;

    scanline_timer #(
        .LINE_CLKS   (T_LINE),
        .NTSC_ACTIVE (T_NTSC_ACT),
        .PAL_ACTIVE  (T_PAL_ACT),
        .NTSC_LINES  (T_NTSC_LINES),
        .PAL_LINES   (T_PAL_LINES)
    ) i_scanline_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .wide_mode_i    (wide_mode_i),
        .pal_mode_i     (pal_mode_i),
        .vint_en_i      (vint_en_i),
        .vint_ack_i     (vint_ack_i),
        .cycle_o        (cycle_o),
        .line_o         (line_o),
        .status_o       (status_o),
        .vint_pending_o (vint_pending_o),
        .next_vint_o    (next_vint_o)
    );

    typedef struct packed {
        logic        wide;
        logic        pal;
        logic [7:0]  line;
        logic [11:0] cyc;
        logic        hb;
        logic        vb;
        logic [31:0] nxt;
    } vec_t;

    // wide, pal, line, cycle, expected hblank, vblank, next interrupt
    localparam vec_t VECS [0:7] = '{
        '{1'b0, 1'b0, 8'd0, 12'd889,  1'b1, 1'b0, 32'd14880},
        '{1'b0, 1'b0, 8'd0, 12'd890,  1'b0, 1'b0, 32'd14880},
        '{1'b1, 1'b0, 8'd0, 12'd911,  1'b1, 1'b0, 32'd14492},
        '{1'b1, 1'b0, 8'd0, 12'd912,  1'b0, 1'b0, 32'd14492},
        '{1'b1, 1'b0, 8'd3, 12'd0,    1'b1, 1'b0, 32'd14492},
        '{1'b1, 1'b0, 8'd4, 12'd2000, 1'b0, 1'b1, 32'hFFFF_FFFF},
        '{1'b0, 1'b1, 8'd4, 12'd100,  1'b1, 1'b0, 32'd21720},
        '{1'b0, 1'b1, 8'd6, 12'd3419, 1'b0, 1'b1, 32'hFFFF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic w, input logic p, input logic en);
        wide_mode_i = w;
        pal_mode_i  = p;
        vint_en_i   = en;
        vint_ack_i  = 1'b0;
        rst_n       = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic goto(input int ln, input int cy);
        for (int n = 0; n < 40000; n++) begin
            if (32'(line_o) == ln && 32'(cycle_o) == cy) return;
            step();
        end
        check("goto", 32'(line_o), 32'(ln));
    endtask

    // Watchdog: an expired run is a failure and still reports.
    always @(posedge clk) begin
        ticks++;
        if (ticks > 195000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<195000", ticks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        // Reset state
        do_reset(1'b0, 1'b0, 1'b1);
        check("R1 reset cycle", 32'(cycle_o), 0);
        check("R2 reset line", 32'(line_o), 0);
        check("R6 reset flag", 32'(vint_pending_o), 0);
        check("R3 reset status", 32'(status_o), 32'h4);
        for (int k = 0; k < 5; k++) step();
        check("R1 count", 32'(cycle_o), 5);

        // Vector table: blank bits and next-interrupt output (R3 R4 R8)
        for (int v = 0; v < 8; v++) begin
            do_reset(VECS[v].wide, VECS[v].pal, 1'b1);
            goto(int'(VECS[v].line), int'(VECS[v].cyc));
            check("R3 hblank", 32'(status_o[2]), 32'(VECS[v].hb));
            check("R4 vblank", 32'(status_o[3]), 32'(VECS[v].vb));
            check("R4 low bits", 32'(status_o[1:0]), 0);
            check("R8 next", next_vint_o, VECS[v].nxt);
        end

        // Wide-mode interrupt set, hold and acknowledge (R5 R6)
        do_reset(1'b1, 1'b0, 1'b1);
        goto(4, 812);
        check("R5 wide before", 32'(vint_pending_o), 0);
        step();
        check("R5 wide set", 32'(vint_pending_o), 1);
        for (int k = 0; k < 100; k++) step();
        check("R6 hold", 32'(vint_pending_o), 1);
        vint_ack_i = 1'b1;
        step();
        vint_ack_i = 1'b0;
        check("R6 ack clears", 32'(vint_pending_o), 0);

        // Narrow-mode set, frame wrap, then ack colliding with set (R5 R2 R6)
        do_reset(1'b0, 1'b0, 1'b1);
        goto(4, 813);
        check("R5 narrow no wide edge", 32'(vint_pending_o), 0);
        goto(4, 1200);
        check("R5 narrow before", 32'(vint_pending_o), 0);
        step();
        check("R5 narrow set", 32'(vint_pending_o), 1);
        vint_ack_i = 1'b1;
        step();
        vint_ack_i = 1'b0;
        check("R6 ack narrow", 32'(vint_pending_o), 0);
        goto(6, 3419);
        check("R4 last line blank", 32'(status_o[3]), 1);
        step();
        check("R2 frame wrap line", 32'(line_o), 0);
        check("R2 frame wrap cycle", 32'(cycle_o), 0);
        goto(4, 1200);
        vint_ack_i = 1'b1;
        step();
        vint_ack_i = 1'b0;
        check("R6 ack priority", 32'(vint_pending_o), 0);
        for (int k = 0; k < 10; k++) step();
        check("R6 ack priority later", 32'(vint_pending_o), 0);

        // Enable low: no flag, no due cycle (R7)
        do_reset(1'b1, 1'b0, 1'b0);
        check("R7 next none", next_vint_o, NONE);
        goto(4, 900);
        check("R7 no flag", 32'(vint_pending_o), 0);
        check("R7 next none late", next_vint_o, NONE);

        // Mid-line mode change takes effect next line (R9 R1)
        do_reset(1'b0, 1'b0, 1'b1);
        goto(0, 100);
        wide_mode_i = 1'b1;
        goto(0, 900);
        check("R9 same line narrow", 32'(status_o[2]), 0);
        goto(0, 3419);
        step();
        check("R1 line advance", 32'(line_o), 1);
        check("R1 cycle wrap", 32'(cycle_o), 0);
        goto(1, 900);
        check("R9 next line wide", 32'(status_o[2]), 1);
        check("R9 next line target", next_vint_o, 32'd14492);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule